// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block gathers the event flags of an SD/MMC host controller into two byte-wide status registers and produces one level-sensitive interrupt request. Single-cycle pulses from the command, data and CRC logic set sticky flags. Three card pins (write-protect, card detect on DATA3, card detect on a general input) are brought in through a synchroniser. Their levels appear in status byte 0, and a change of the chosen card-detect pin raises its own flags.

Software reaches the status, mask and control bytes through a plain register port. Writes are single-cycle. Reads are combinational on the address. A status flag is cleared by writing a one to its position. The interrupt goes high when the global enable in the control byte is set and any flag is set whose mask bit is also set.

Top module: `sd_irq_status_unit`

## Requirements
- R1: After reset every status flag, both mask bytes and the control byte read zero, and `irq_o` is low.
- R2: Status byte 1 (address 1) holds sticky flags. Bit1 is command-response done, bit2 response timeout, bit3 auto-stop done, bit4 data timeout, bit5 response CRC error, bit6 read CRC error and bit7 write CRC error. A one-cycle pulse sets its flag, and the register read shows it from the cycle after the pulse.
- R3: Status byte 0 (address 0) holds sticky flags at bit4 (multi-block done), bit5 (block done), bit6 (card-detect change) and bit7 (device inserted). A flag stays set until it is cleared.
- R4: A write to address 0 or 1 clears each sticky flag whose write-data bit is one and leaves the others alone. The value 0xFF clears the whole byte.
- R5: When an event pulse arrives in the same cycle as a clear write to its flag, the flag is set afterwards.
- R6: Status byte 0 bit1 shows the write-protect pin, bit2 the DATA3 card-detect pin and bit3 the general-input card-detect pin. Each pin passes through a two-flop synchroniser. These bits are read-only, and a write of ones to address 0 leaves them unchanged.
- R7: Address 2 is mask byte 0, with bits 7:4 writable and bits 3:0 reading zero. Address 3 is mask byte 1, with bits 7:1 writable and bit0 reading zero. A mask bit sits at the same position as the status flag it enables.
- R8: Address 4 is the control byte, and its bit7 is the global interrupt enable. `irq_o` is high exactly when bit7 is set and some status flag is set together with its mask bit. A masked event therefore raises `irq_o` in the cycle after its pulse.
- R9: Control bit5 selects the card-detect source: one selects the general-input pin and zero selects the DATA3 pin. A change of the selected synchronised level sets status byte 0 bit6. Changes of the other pin, and changes of the select bit itself, set nothing.
- R10: Status byte 0 bit7 is set by the insertion pulse input. It is also set when the selected card-detect level changes into its present state. The present state is a high level when control bit4 is one and a low level when it is zero. A change of bit4 alone sets nothing.
- R11: Bit0 of both status bytes, the unused control bits (6, 3:0) and any address above 4 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cmd_done | input | 1 | Command-response done pulse |
| ev_rsp_timeout | input | 1 | Response timeout pulse |
| ev_autostop_done | input | 1 | Auto-stop done pulse |
| ev_data_timeout | input | 1 | Data timeout pulse |
| ev_rsp_crc_err | input | 1 | Response CRC error pulse |
| ev_rd_crc_err | input | 1 | Read-data CRC error pulse |
| ev_wr_crc_err | input | 1 | Write-data CRC error pulse |
| ev_blk_done | input | 1 | Block done pulse |
| ev_mblk_done | input | 1 | Multi-block done pulse |
| ev_card_ins | input | 1 | Device inserted pulse |
| pin_wp | input | 1 | Write-protect pin, asynchronous |
| pin_cd_dat3 | input | 1 | Card detect sensed on DATA3, asynchronous |
| pin_cd_gpi | input | 1 | Card detect on general input, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong flag register shows up on the status read one cycle after the pulse or clear that disturbed it, and at `irq_o` in that same cycle if the flag is masked in. A card-detect tracker that holds the wrong previous level gives a spurious or missing bit6 or bit7 three clock edges after the pin moves. A synchroniser fault moves the level bits away from the two-edge latency. A clear that reaches the wrong bits is visible at once on the next read of the written byte.

// File: rtl/sdis_pkg.sv
package sdis_pkg;

  typedef logic [7:0] byte_t;

  // register addresses
  localparam int ADR_STAT0 = 0;
  localparam int ADR_STAT1 = 1;
  localparam int ADR_MASK0 = 2;
  localparam int ADR_MASK1 = 3;
  localparam int ADR_CTRL  = 4;

  // which bits hold state in each byte
  localparam byte_t KEEP_STAT0 = 8'hF0;
  localparam byte_t KEEP_STAT1 = 8'hFE;
  localparam byte_t KEEP_MASK0 = 8'hF0;
  localparam byte_t KEEP_MASK1 = 8'hFE;
  localparam byte_t KEEP_CTRL  = 8'hB0;

  // control byte fields
  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_SRC_BIT = 5;
  localparam int CTRL_POL_BIT = 4;

  // number of sticky status bytes
  localparam int N_STAT = 2;

  function automatic byte_t keep_of(input int idx);
    return (idx == 0) ? KEEP_STAT0 : KEEP_STAT1;
  endfunction

  // next value of a sticky byte: clear first, then new events win
  function automatic byte_t w1c_next(input byte_t cur, input byte_t set,
                                     input byte_t clr, input byte_t keep);
    return ((cur & ~clr) | set) & keep;
  endfunction

  function automatic logic cd_present(input logic lvl, input logic pol_high);
    return pol_high ? lvl : ~lvl;
  endfunction

  function automatic logic irq_pending(input byte_t s0, input byte_t m0,
                                       input byte_t s1, input byte_t m1,
                                       input logic en);
    return en & ((|(s0 & m0)) | (|(s1 & m1)));
  endfunction

endpackage

// File: rtl/sdis_pin_sync.sv
module sdis_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

  // age counter so the latency check never looks before reset
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;

  generate
    if (STAGES == 2) begin : g_chk
      // R6: level shows up exactly two edges after the pin
      p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (sync_o == $past(pin_i, 2)));
    end
  endgenerate

endmodule

// File: rtl/sdis_sticky_byte.sv
module sdis_sticky_byte
  import sdis_pkg::*;
#(
  parameter byte_t KEEP = 8'hFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t set_vec,
  input  logic  clr_en,
  input  byte_t clr_vec,
  output byte_t q
);

  byte_t clr_eff;
  assign clr_eff = clr_en ? clr_vec : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= w1c_next(q, set_vec, clr_eff, KEEP);

  // R5: an event sets its bit even when a clear lands in the same cycle
  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & KEEP) != 0) |=> ((q & $past(set_vec & KEEP)) == $past(set_vec & KEEP)));

  // R4: cleared bits without a new event are low next cycle
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(clr_vec & ~set_vec)) == 8'h00));

  // R3: with no event and no clear the flags hold
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && ((set_vec & KEEP) == 0)) |=> $stable(q));

endmodule

// File: rtl/sdis_cd_track.sv
module sdis_cd_track
  import sdis_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dat3_s,
  input  logic gpi_s,
  input  logic src_gpi,
  input  logic pol_high,
  output logic chg_evt,
  output logic ins_evt
);

  logic dat3_q, gpi_q;
  logic sel_lvl;

  // each pin keeps its own history so a source switch is silent
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dat3_q <= 1'b0;
      gpi_q  <= 1'b0;
    end else begin
      dat3_q <= dat3_s;
      gpi_q  <= gpi_s;
    end

  assign sel_lvl = src_gpi ? gpi_s : dat3_s;
  assign chg_evt = src_gpi ? (gpi_s ^ gpi_q) : (dat3_s ^ dat3_q);
  assign ins_evt = chg_evt & cd_present(sel_lvl, pol_high);

  // R9: a change flag needs the selected level to have moved
  p_chg_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> (src_gpi ? !$stable(gpi_s) : !$stable(dat3_s)));

endmodule

// File: rtl/sd_irq_status_unit.sv
module sd_irq_status_unit
  import sdis_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cmd_done,
  input  logic              ev_rsp_timeout,
  input  logic              ev_autostop_done,
  input  logic              ev_data_timeout,
  input  logic              ev_rsp_crc_err,
  input  logic              ev_rd_crc_err,
  input  logic              ev_wr_crc_err,
  input  logic              ev_blk_done,
  input  logic              ev_mblk_done,
  input  logic              ev_card_ins,
  input  logic              pin_wp,
  input  logic              pin_cd_dat3,
  input  logic              pin_cd_gpi,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_o
);

  localparam int N_PINS = 3;

  // ---------------- pin synchronisation ----------------
  logic [N_PINS-1:0] pins_raw, pins_s;
  logic wp_s, dat3_s, gpi_s;

  assign pins_raw = {pin_cd_gpi, pin_cd_dat3, pin_wp};

  sdis_pin_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins_raw),
    .sync_o(pins_s)
  );

  assign wp_s   = pins_s[0];
  assign dat3_s = pins_s[1];
  assign gpi_s  = pins_s[2];

  // ---------------- decode ----------------
  logic wr_stat0, wr_stat1, wr_mask0, wr_mask1, wr_ctrl;
  assign wr_stat0 = reg_wr && (reg_addr == ADDR_W'(ADR_STAT0));
  assign wr_stat1 = reg_wr && (reg_addr == ADDR_W'(ADR_STAT1));
  assign wr_mask0 = reg_wr && (reg_addr == ADDR_W'(ADR_MASK0));
  assign wr_mask1 = reg_wr && (reg_addr == ADDR_W'(ADR_MASK1));
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));

  // ---------------- mask and control bytes ----------------
  byte_t mask0_q, mask1_q, ctrl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask0_q <= '0;
      mask1_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_mask0) mask0_q <= reg_wdata & KEEP_MASK0;
      if (wr_mask1) mask1_q <= reg_wdata & KEEP_MASK1;
      if (wr_ctrl)  ctrl_q  <= reg_wdata & KEEP_CTRL;
    end

  logic irq_en, src_gpi, pol_high;
  assign irq_en   = ctrl_q[CTRL_EN_BIT];
  assign src_gpi  = ctrl_q[CTRL_SRC_BIT];
  assign pol_high = ctrl_q[CTRL_POL_BIT];

  // ---------------- card-detect tracking ----------------
  logic cd_chg_evt, cd_ins_evt;

  sdis_cd_track u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .dat3_s  (dat3_s),
    .gpi_s   (gpi_s),
    .src_gpi (src_gpi),
    .pol_high(pol_high),
    .chg_evt (cd_chg_evt),
    .ins_evt (cd_ins_evt)
  );

  // ---------------- sticky status bytes ----------------
  byte_t set_vec [N_STAT];
  byte_t stk_q   [N_STAT];
  logic  clr_en  [N_STAT];

  assign set_vec[0] = {ev_card_ins | cd_ins_evt, cd_chg_evt,
                       ev_blk_done, ev_mblk_done, 4'b0000};
  assign set_vec[1] = {ev_wr_crc_err, ev_rd_crc_err, ev_rsp_crc_err,
                       ev_data_timeout, ev_autostop_done, ev_rsp_timeout,
                       ev_cmd_done, 1'b0};
  assign clr_en[0]  = wr_stat0;
  assign clr_en[1]  = wr_stat1;

  genvar b;
  generate
    for (b = 0; b < N_STAT; b++) begin : g_stat
      sdis_sticky_byte #(.KEEP(keep_of(b))) u_byte (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec[b]),
        .clr_en (clr_en[b]),
        .clr_vec(reg_wdata),
        .q      (stk_q[b])
      );
    end
  endgenerate

  byte_t stat0_view, stat1_view;
  assign stat0_view = stk_q[0] | {4'b0000, gpi_s, dat3_s, wp_s, 1'b0};
  assign stat1_view = stk_q[1];

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      ADDR_W'(ADR_STAT0): reg_rdata = stat0_view;
      ADDR_W'(ADR_STAT1): reg_rdata = stat1_view;
      ADDR_W'(ADR_MASK0): reg_rdata = mask0_q;
      ADDR_W'(ADR_MASK1): reg_rdata = mask1_q;
      ADDR_W'(ADR_CTRL):  reg_rdata = ctrl_q;
      default:            reg_rdata = 8'h00;
    endcase
  end

  // ---------------- interrupt ----------------
  assign irq_o = irq_pending(stk_q[0], mask0_q, stk_q[1], mask1_q, irq_en);

  // R8: the output is never high while the global enable is off
  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en);

  // R8: a masked event with the enable set raises the request next cycle
  p_event_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !reg_wr && ((set_vec[1] & mask1_q) != 0)) |=> irq_o);

endmodule

// File: tb/tb_sd_irq_status_unit.sv
module tb_sd_irq_status_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] ev = '0;   // 0 cmd,1 rsp_tmo,2 autostop,3 data_tmo,4 rsp_crc,5 rd_crc,6 wr_crc,7 blk,8 mblk,9 ins
  logic       pin_wp = 1'b0, pin_cd_dat3 = 1'b0, pin_cd_gpi = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  sd_irq_status_unit dut (
    .clk(clk), .rst_n(rst_n),
    .ev_cmd_done(ev[0]), .ev_rsp_timeout(ev[1]), .ev_autostop_done(ev[2]),
    .ev_data_timeout(ev[3]), .ev_rsp_crc_err(ev[4]), .ev_rd_crc_err(ev[5]),
    .ev_wr_crc_err(ev[6]), .ev_blk_done(ev[7]), .ev_mblk_done(ev[8]),
    .ev_card_ins(ev[9]),
    .pin_wp(pin_wp), .pin_cd_dat3(pin_cd_dat3), .pin_cd_gpi(pin_cd_gpi),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // {events[9:0], expected status0, expected status1}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {10'h001, 8'h00, 8'h02}, {10'h002, 8'h00, 8'h04},
    {10'h004, 8'h00, 8'h08}, {10'h008, 8'h00, 8'h10},
    {10'h010, 8'h00, 8'h20}, {10'h020, 8'h00, 8'h40},
    {10'h040, 8'h00, 8'h80}, {10'h080, 8'h20, 8'h00},
    {10'h100, 8'h10, 8'h00}, {10'h200, 8'h80, 8'h00},
    {10'h07F, 8'h00, 8'hFE}, {10'h385, 8'hB0, 8'h0A}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", what, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_addr = 3'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] e);
    @(negedge clk);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic settle_pins();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, d); check(d, 8'h00, $sformatf("R1 reset addr %0d", a));
    end
    check({7'b0, irq_o}, 8'h00, "R1 irq after reset");

    // R2 R3: table of event patterns
    for (int i = 0; i < NV; i++) begin
      wr(0, 8'hFF); wr(1, 8'hFF);
      pulse(VEC[i][25:16]);
      rd(0, d); check(d, VEC[i][15:8], $sformatf("R3 vec %0d status0", i));
      rd(1, d); check(d, VEC[i][7:0],  $sformatf("R2 vec %0d status1", i));
    end

    // R3: flags stay set over idle cycles
    repeat (5) @(negedge clk);
    rd(0, d); check(d, 8'hB0, "R3 sticky hold status0");

    // R4: partial clear
    wr(1, 8'hFF);
    pulse(10'h07F);
    wr(1, 8'h0A);
    rd(1, d); check(d, 8'hF4, "R4 partial clear status1");
    wr(0, 8'h20);
    rd(0, d); check(d, 8'h90, "R4 partial clear status0");
    wr(1, 8'hFF);
    rd(1, d); check(d, 8'h00, "R4 full clear status1");

    // R5: event and clear in the same cycle
    wr(0, 8'hFF);
    @(negedge clk);
    ev = 10'h080; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'hFF;
    @(negedge clk);
    ev = '0; reg_wr = 1'b0;
    rd(0, d); check(d, 8'h20, "R5 event wins over clear");

    // R7: mask writability
    wr(2, 8'hFF); rd(2, d); check(d, 8'hF0, "R7 mask0 writable bits");
    wr(3, 8'hFF); rd(3, d); check(d, 8'hFE, "R7 mask1 writable bits");
    wr(2, 8'h00); wr(3, 8'h00);

    // R11: control and unused addresses
    wr(4, 8'hFF); rd(4, d); check(d, 8'hB0, "R11 control unused bits");
    wr(4, 8'h00);
    wr(5, 8'hFF); rd(5, d); check(d, 8'h00, "R11 address 5");
    rd(7, d); check(d, 8'h00, "R11 address 7");

    // R8: interrupt gating
    wr(0, 8'hFF); wr(1, 8'hFF);
    wr(3, 8'h04);
    pulse(10'h002);
    check({7'b0, irq_o}, 8'h00, "R8 irq low without enable");
    wr(4, 8'h80);
    check({7'b0, irq_o}, 8'h01, "R8 irq high with enable");
    wr(1, 8'hFF);
    check({7'b0, irq_o}, 8'h00, "R8 irq drops after clear");
    pulse(10'h001);
    check({7'b0, irq_o}, 8'h00, "R8 unmasked event no irq");
    wr(1, 8'hFF);
    @(negedge clk);
    ev = 10'h002;
    @(negedge clk);
    ev = '0;
    check({7'b0, irq_o}, 8'h01, "R8 irq in cycle after pulse");
    wr(1, 8'hFF);
    wr(2, 8'h20);
    pulse(10'h080);
    check({7'b0, irq_o}, 8'h01, "R8 mask0 block done irq");
    wr(4, 8'h00); wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'hFF);

    // R6: level bits follow pins, read-only
    @(negedge clk); pin_wp = 1'b1; settle_pins();
    rd(0, d); check(d, 8'h02, "R6 write-protect level");
    wr(0, 8'hFF);
    rd(0, d); check(d, 8'h02, "R6 level ignores write");
    @(negedge clk); pin_wp = 1'b0; settle_pins();
    rd(0, d); check(d, 8'h00, "R6 write-protect released");

    // R9 R10: DATA3 source, low-active present
    @(negedge clk); pin_cd_dat3 = 1'b1; settle_pins();
    rd(0, d); check(d, 8'h44, "R9 dat3 rise sets change only");
    wr(0, 8'hFF);
    @(negedge clk); pin_cd_dat3 = 1'b0; settle_pins();
    rd(0, d); check(d, 8'hC0, "R10 dat3 fall is insertion (low active)");
    wr(0, 8'hFF);
    @(negedge clk); pin_cd_gpi = 1'b1; settle_pins();
    rd(0, d); check(d, 8'h08, "R9 unselected gpi ignored");
    @(negedge clk); pin_cd_gpi = 1'b0; settle_pins();

    // R9 R10: general-input source, high-active present
    wr(4, 8'h30);
    settle_pins();
    rd(0, d); check(d, 8'h00, "R10 select and polarity change silent");
    @(negedge clk); pin_cd_gpi = 1'b1; settle_pins();
    rd(0, d); check(d, 8'hC8, "R10 gpi rise is insertion (high active)");
    wr(0, 8'hFF);
    @(negedge clk); pin_cd_dat3 = 1'b1; settle_pins();
    rd(0, d); check(d, 8'h0C, "R9 unselected dat3 ignored");
    @(negedge clk); pin_cd_gpi = 1'b0; settle_pins();
    rd(0, d); check(d, 8'h44, "R9 gpi fall change without insertion");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule